// File: doc/BRIEF.md
# Arrow Key Escape Sequence Expander

This block sits between a keyboard scanner that delivers one keycode at a time and a character consumer such as a console. Each keycode it takes is turned into characters in a small first-in first-out character queue. An ordinary keycode becomes one character. The four cursor keycodes become the three-byte terminal escape sequences for left, right, up and down. A zero keycode is taken and discarded.

The consumer reads the character at the head of the queue and pops it. It can also poll a flag that says whether any character is waiting. The block asks for a new keycode only when the queue is empty and no expansion is still in flight. Because of this, a whole expansion always fits in the four-entry queue, and the queue can never overflow. A pop on an empty queue has no effect, but it leaves a sticky error flag set until reset.

Top module: `esc_seq_expander`

## Requirements
- R1: After synchronous active-high reset, `char_avail` is 0, `refill_req` is 1 and `underflow_err` is 0.
- R2: `refill_req` is 1 exactly when the queue holds no character and no expansion is pending. A keycode is taken only in a cycle where `key_valid` and `refill_req` are both 1. A `key_valid` in any other cycle is ignored and adds no character.
- R3: A nonzero keycode outside 0x1C..0x1F is written as one character equal to the keycode. If the keycode is taken at clock edge k, `char_avail` is 1 and `char_out` equals the keycode after edge k+1.
- R4: Keycode 0 is taken but writes nothing, so `refill_req` stays 1 and `char_avail` stays 0.
- R5: Each cursor keycode expands to three characters, written on edges k+1, k+2 and k+3. The first is 0x1B and the second is 0x5B. The third is 0x44 for 0x1C, 0x43 for 0x1D, 0x41 for 0x1E and 0x42 for 0x1F.
- R6: `char_out` shows the oldest character while `char_avail` is 1. A `pop` in such a cycle removes that character at the next edge. Characters leave in the order they were written, including when pops overlap an expansion.
- R7: A `pop` while `char_avail` is 0 changes no character, and it sets `underflow_err` from the next edge on. Only reset clears `underflow_err`.
- R8: The queue never holds more than three characters, and no write ever lands in a full queue.
- R9: After a nonzero keycode is taken, `refill_req` is 0 from the next edge. It returns to 1 only after the last character of that keycode has been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_code | input | CW | Keycode from the scanner |
| key_valid | input | 1 | Keycode strobe, honoured only while `refill_req` is 1 |
| pop | input | 1 | Remove the head character |
| char_out | output | CW | Head character of the queue (registered) |
| char_avail | output | 1 | Queue holds at least one character (registered) |
| refill_req | output | 1 | Queue empty and idle, ready for a keycode (registered) |
| underflow_err | output | 1 | Sticky flag for a pop on an empty queue |

## Verification
The bench builds the block with its defaults: 8-bit characters and a four-entry queue. That makes every one of the 256 keycode values reachable, and the bench sweeps all of them. For each keycode it works out the expected character string arithmetically. Along the sweep it alternates three ways of draining: lazy draining after the full expansion, which fills the queue to three; eager popping that overlaps the writes; and stray keycode strobes held while the block is busy. The underflow flag and its stickiness are checked after the sweep, and a second reset is checked as well.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

  localparam logic [7:0] CH_ESC     = 8'h1B;
  localparam logic [7:0] CH_BRACKET = 8'h5B;
  localparam logic [7:0] KEY_LEFT   = 8'h1C;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_BRACKET = 2'd1,
    PH_FINAL   = 2'd2
  } phase_e;

  // Low two bits of a cursor keycode select the closing letter.
  function automatic logic [7:0] arrow_letter(input logic [1:0] sel);
    logic [7:0] r;
    case (sel)
      2'd0:    r = 8'h44;
      2'd1:    r = 8'h43;
      2'd2:    r = 8'h41;
      default: r = 8'h42;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/esc_key_expand.sv
module esc_key_expand
  import esc_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [CW-1:0] key_code,
  output logic          wr_en,
  output logic [CW-1:0] wr_data,
  output logic          wr_en_nxt
);

  localparam logic [CW-1:0] ARROW_BASE = CW'(KEY_LEFT);

  phase_e        phase_q, phase_n;
  logic          wr_en_q, wr_en_n;
  logic [CW-1:0] data_q, data_n;
  logic [CW-1:0] final_q, final_n;
  logic          is_arrow;
  logic          is_zero;

  assign is_arrow = (key_code[CW-1:2] == ARROW_BASE[CW-1:2]);
  assign is_zero  = (key_code == '0);

  always_comb begin
    wr_en_n = 1'b0;
    data_n  = data_q;
    phase_n = PH_IDLE;
    final_n = final_q;
    case (phase_q)
      PH_BRACKET: begin
        wr_en_n = 1'b1;
        data_n  = CW'(CH_BRACKET);
        phase_n = PH_FINAL;
      end
      PH_FINAL: begin
        wr_en_n = 1'b1;
        data_n  = final_q;
        phase_n = PH_IDLE;
      end
      default: begin
        if (take && !is_zero) begin
          wr_en_n = 1'b1;
          if (is_arrow) begin
            data_n  = CW'(CH_ESC);
            phase_n = PH_BRACKET;
            final_n = CW'(arrow_letter(key_code[1:0]));
          end else begin
            data_n  = key_code;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      wr_en_q <= 1'b0;
      data_q  <= '0;
      final_q <= '0;
    end else begin
      phase_q <= phase_n;
      wr_en_q <= wr_en_n;
      data_q  <= data_n;
      final_q <= final_n;
    end
  end

  assign wr_en     = wr_en_q;
  assign wr_data   = data_q;
  assign wr_en_nxt = wr_en_n;

  // R2: a keycode is only taken while no expansion is running
  assert_take_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> (phase_q == PH_IDLE && !wr_en_q));

  // R5: the bracket always follows the escape character on the next edge
  assert_bracket_after_esc_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BRACKET) |=> (wr_en_q && wr_data == CW'(CH_BRACKET)));

endmodule

// File: rtl/esc_char_fifo.sv
module esc_char_fifo #(
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          pop,
  output logic [CW-1:0] head,
  output logic          avail,
  output logic          empty_nxt
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [CW-1:0] mem [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q, rptr_n, wptr_n;
  logic [PW-1:0] count, count_n;
  logic [CW-1:0] head_q, head_n;
  logic          avail_q;
  logic          do_pop;

  assign count  = wptr_q - rptr_q;
  assign do_pop = pop && (count != '0);

  always_comb begin
    rptr_n  = rptr_q + (do_pop ? PW'(1) : PW'(0));
    wptr_n  = wptr_q + (wr_en ? PW'(1) : PW'(0));
    count_n = wptr_n - rptr_n;
    if (wr_en && (wptr_q[AW-1:0] == rptr_n[AW-1:0]))
      head_n = wr_data;
    else
      head_n = mem[rptr_n[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      head_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      rptr_q  <= rptr_n;
      wptr_q  <= wptr_n;
      head_q  <= head_n;
      avail_q <= (count_n != '0);
    end
  end

  assign head      = head_q;
  assign avail     = avail_q;
  assign empty_nxt = (count_n == '0);

  // R8: no write ever lands in a full queue
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < PW'(DEPTH)));

  // R8: occupancy stays at three or below
  assert_max_three_R8: assert property (@(posedge clk) disable iff (rst)
    count <= PW'(3));

  // R6: without a pop the head character holds while the queue is non-empty
  assert_head_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (avail_q && !pop) |=> (avail_q && $stable(head_q)));

endmodule

// File: rtl/esc_poll_ctl.sv
module esc_poll_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pop,
  input  logic avail,
  input  logic empty_nxt,
  input  logic wr_en_nxt,
  output logic refill_req,
  output logic underflow_err
);

  logic refill_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      refill_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      refill_q <= empty_nxt && !wr_en_nxt;
      err_q    <= err_q || (pop && !avail);
    end
  end

  assign refill_req    = refill_q;
  assign underflow_err = err_q;

  // R7: the underflow flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/esc_seq_expander.sv
module esc_seq_expander #(
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] key_code,
  input  logic          key_valid,
  input  logic          pop,
  output logic [CW-1:0] char_out,
  output logic          char_avail,
  output logic          refill_req,
  output logic          underflow_err
);

  logic          take;
  logic          wr_en;
  logic [CW-1:0] wr_data;
  logic          wr_en_nxt;
  logic          empty_nxt;

  assign take = key_valid && refill_req;

  esc_key_expand #(.CW(CW)) i_expand (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .key_code  (key_code),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_en_nxt (wr_en_nxt)
  );

  esc_char_fifo #(.CW(CW), .DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pop       (pop),
    .head      (char_out),
    .avail     (char_avail),
    .empty_nxt (empty_nxt)
  );

  esc_poll_ctl i_ctl (
    .clk           (clk),
    .rst           (rst),
    .pop           (pop),
    .avail         (char_avail),
    .empty_nxt     (empty_nxt),
    .wr_en_nxt     (wr_en_nxt),
    .refill_req    (refill_req),
    .underflow_err (underflow_err)
  );

  // R2: a refill is only requested while no character waits
  assert_refill_only_empty_R2: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> !char_avail);

  // R9: a nonzero keycode withdraws the refill request at once
  assert_refill_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (take && key_code != '0) |=> !refill_req);

  // R7: a pop on an empty queue raises the error flag
  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && !char_avail) |=> underflow_err);

  // R3: a plain keycode appears at the head two edges after it is taken
  assert_plain_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (take && key_code != '0 && key_code[CW-1:2] != 6'h07)
      |-> ##2 (char_avail && char_out == $past(key_code, 2)));

endmodule

// File: tb/test_esc_seq_expander.sv
`timescale 1ns/1ps
module test_esc_seq_expander;

  localparam int CW    = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] key_code = '0;
  logic          key_valid = 1'b0;
  logic          pop = 1'b0;
  logic [CW-1:0] char_out;
  logic          char_avail;
  logic          refill_req;
  logic          underflow_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  esc_seq_expander #(.CW(CW), .DEPTH(DEPTH)) i_esc_seq_expander (
    .clk           (clk),
    .rst           (rst),
    .key_code      (key_code),
    .key_valid     (key_valid),
    .pop           (pop),
    .char_out      (char_out),
    .char_avail    (char_avail),
    .refill_req    (refill_req),
    .underflow_err (underflow_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int k);
    if (k == 0) return 0;
    if (k >= 28 && k <= 31) return 3;
    return 1;
  endfunction

  function automatic int exp_chr(input int k, input int i);
    int letter;
    if (k < 28 || k > 31) return k;
    if (i == 0) return 27;
    if (i == 1) return 91;
    case (k)
      28: letter = 68;
      29: letter = 67;
      30: letter = 65;
      default: letter = 66;
    endcase
    return letter;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(char_avail == 1'b0, "R1 char_avail after reset", int'(char_avail), 0);
    chk(refill_req == 1'b1, "R1 refill_req after reset", int'(refill_req), 1);
    chk(underflow_err == 1'b0, "R1 underflow_err after reset", int'(underflow_err), 0);
  endtask

  task automatic drain(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      while (!char_avail) @(negedge clk);
      chk(char_out == CW'(exp_chr(k, i)), "R6 head order", int'(char_out), exp_chr(k, i));
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
    end
    chk(char_avail == 1'b0, "R8 R2 no extra character", int'(char_avail), 0);
    chk(refill_req == 1'b1, "R9 refill after last pop", int'(refill_req), 1);
  endtask

  task automatic run_key(input int k, input bit eager, input bit intrude);
    int n;
    n = exp_len(k);
    while (!refill_req) @(negedge clk);
    key_code  = CW'(k);
    key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    if (n == 0) begin
      chk(refill_req == 1'b1, "R4 zero keeps refill", int'(refill_req), 1);
      chk(char_avail == 1'b0, "R4 zero writes nothing", int'(char_avail), 0);
      return;
    end
    chk(refill_req == 1'b0, "R9 refill drops", int'(refill_req), 0);
    chk(char_avail == 1'b0, "R3 not yet written", int'(char_avail), 0);
    if (eager) begin
      drain(k, n);
    end else begin
      if (intrude) begin
        key_code  = 8'h41;
        key_valid = 1'b1;
      end
      @(negedge clk);
      chk(char_avail == 1'b1, (n == 3) ? "R5 first char present" : "R3 char present",
          int'(char_avail), 1);
      chk(char_out == CW'(exp_chr(k, 0)), (n == 3) ? "R5 first char value" : "R3 char value",
          int'(char_out), exp_chr(k, 0));
      @(negedge clk);
      @(negedge clk);
      key_valid = 1'b0;
      chk(refill_req == 1'b0, "R9 refill low while chars wait", int'(refill_req), 0);
      if (n == 3)
        chk(char_out == CW'(exp_chr(k, 0)), "R5 head still escape", int'(char_out), 27);
      drain(k, n);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    for (int k = 0; k < 256; k++) begin
      run_key(k, k[0], k[1] && !k[0]);
      chk(underflow_err == 1'b0, "R7 no spurious error", int'(underflow_err), 0);
    end
    // R7: pop on an empty queue
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk(underflow_err == 1'b1, "R7 error set", int'(underflow_err), 1);
    chk(char_avail == 1'b0, "R7 nothing appeared", int'(char_avail), 0);
    chk(refill_req == 1'b1, "R7 refill unaffected", int'(refill_req), 1);
    run_key(8'h5A, 1'b0, 1'b0);
    chk(underflow_err == 1'b1, "R7 error sticky", int'(underflow_err), 1);
    do_reset();
    run_key(8'h1E, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule